// File: doc/BRIEF.md
# Dual-Reload Down-Counter with PWM and Event Counting

This block is a 16-bit down-counter that alternates between two 16-bit reload values. In waveform mode it decrements once per qualified `tick` cycle. When it underflows, it reloads, first from reload value A and then from B, A, B and so on. Each underflow toggles `pwm_out`, so the high time and the low time of the output are set independently by the two reload values. Every reload records a pending flag of its own: one flag for A, one for B. Two enable bits decide which pending flags drive `irq`, so software can take an interrupt on the rising edge of the waveform, on the falling edge, or on both.

In event mode the counter decrements on a selected edge of `pin_a`. The edge is rising or falling, chosen by the mode code. An underflow reloads from A and sets only flag A. A rising edge on `pin_b` sets flag B, which turns that pin into an interrupt input. Both pins pass through a two-flop synchronizer and an edge detector before they are used. Software reaches the reload values, the counter, the control byte and the flags through a byte-wide port with 8-bit addresses. Reads are combinational and writes take effect at the clock edge.

A state machine sequences the counter. It has four states:
- STOPPED: the counter holds its value and accepts writes.
- PWM_NEXT_A: the next underflow loads A.
- PWM_NEXT_B: the next underflow loads B.
- EVENT: the counter is driven by pin edges.

Its transitions are:
- arm: STOPPED or EVENT to PWM_NEXT_A, when the mode becomes waveform.
- flip: PWM_NEXT_A to PWM_NEXT_B, and PWM_NEXT_B to PWM_NEXT_A, on each underflow.
- to_event: any state to EVENT, when an event mode is selected.
- halt: any state to STOPPED, when the mode is 00.

Top module: `dual_reload_timer`

## Requirements
- R1: After reset, every register reads 0x00, and `irq` and `pwm_out` are 0.
- R2: The register map is as follows.
  - 0x00/0x01: counter, low and high byte.
  - 0x02/0x03: reload A, low and high byte.
  - 0x04/0x05: reload B, low and high byte.
  - 0x06: control. Bits [1:0] are the mode, bit 2 enables A and bit 3 enables B.
  - 0x07: flags. Bit 0 is pending A and bit 1 is pending B.
  - Any other address reads 0x00.
- R3: Writing a counter byte sets that byte only while the block is stopped. While the block is running, such writes are ignored.
- R4: In waveform mode (mode 01), each `tick` decrements the counter. A `tick` at count 0 is an underflow. The first underflow after arming reloads from A, and later underflows alternate B, A, B.
- R5: `pwm_out` toggles on every waveform underflow. It is 0 whenever the block is not in waveform mode.
- R6: An underflow that reloads from A sets pending A. One that reloads from B sets pending B.
- R7: Pending flags stay set until a write of 1 to their bit in 0x07 clears them. If a flag is set and cleared in the same cycle, the set wins.
- R8: `irq` = (pending A & enable A) | (pending B & enable B).
- R9: In mode 10 the counter decrements on rising edges of `pin_a`, and in mode 11 on falling edges. `tick` has no effect in these modes.
- R10: An underflow in event mode reloads from A and sets only pending A.
- R11: A rising edge of `pin_b` sets pending B in event mode and has no effect in waveform mode.
- R12: In mode 00 the counter holds its value. Moving from 00 to 01 restarts the sequence so that the next reload is from A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count qualifier for waveform mode |
| bus_addr | input | 8 | Register address for reads and writes |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| pin_a | input | 1 | Event count input (asynchronous) |
| pin_b | input | 1 | Interrupt pin input (asynchronous) |
| pwm_out | output | 1 | Waveform output |
| irq | output | 1 | Interrupt request |

## Verification
Waveform mode is stepped with single `tick` pulses and distinct reload values A=2 and B=1. This shows whether a reload came from A or from B, and whether alternation survives a stop and re-arm begun mid-cycle. A clear of both flags is written in the same cycle as a B underflow, which separates "set wins" from "clear wins". Event mode is driven with full pin pulses in rising and in falling polarity, which shows which edge counts. Stray `tick` pulses and `pin_b` pulses are applied in the modes where they must be ignored.

// File: rtl/drt_pkg.sv
package drt_pkg;
    localparam int CNT_W  = 16;
    localparam int BUS_W  = 8;
    localparam int ADDR_W = 8;
    localparam int NFLAG  = 2;

    typedef enum logic [1:0] {
        MODE_STOP     = 2'b00,
        MODE_PWM      = 2'b01,
        MODE_EVT_RISE = 2'b10,
        MODE_EVT_FALL = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        ST_STOPPED    = 2'b00,
        ST_PWM_NEXT_A = 2'b01,
        ST_PWM_NEXT_B = 2'b10,
        ST_EVENT      = 2'b11
    } state_e;

    localparam logic [ADDR_W-1:0] ADR_CNT_LO = 8'h00;
    localparam logic [ADDR_W-1:0] ADR_CNT_HI = 8'h01;
    localparam logic [ADDR_W-1:0] ADR_RA_LO  = 8'h02;
    localparam logic [ADDR_W-1:0] ADR_RA_HI  = 8'h03;
    localparam logic [ADDR_W-1:0] ADR_RB_LO  = 8'h04;
    localparam logic [ADDR_W-1:0] ADR_RB_HI  = 8'h05;
    localparam logic [ADDR_W-1:0] ADR_CTRL   = 8'h06;
    localparam logic [ADDR_W-1:0] ADR_FLAG   = 8'h07;
endpackage

// File: rtl/drt_pin_sync.sv
module drt_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic fall_sel,
    output logic edge_det
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin};
            prev_q <= sync_q[STAGES-1];
        end
    end

    always_comb begin
        if (fall_sel) edge_det = prev_q & ~sync_q[STAGES-1];
        else          edge_det = ~prev_q & sync_q[STAGES-1];
    end
endmodule

// File: rtl/drt_core.sv
module drt_core
    import drt_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  mode_e        mode,
    input  logic         tick,
    input  logic         pin_edge,
    input  logic         wr_cnt_lo,
    input  logic         wr_cnt_hi,
    input  logic [7:0]   wdata,
    input  logic [W-1:0] reload_a,
    input  logic [W-1:0] reload_b,
    output logic [W-1:0] count,
    output logic         uf_a,
    output logic         uf_b,
    output logic         in_event,
    output logic         pwm
);
    localparam int HI_W = W - 8;

    state_e       state, state_nx;
    logic         dec, uf;
    logic [W-1:0] reload_val;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_STOPPED;
        else        state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_STOPPED: begin
                if (mode == MODE_PWM)       state_nx = ST_PWM_NEXT_A;
                else if (mode[1])           state_nx = ST_EVENT;
            end
            ST_PWM_NEXT_A: begin
                if (mode == MODE_STOP)      state_nx = ST_STOPPED;
                else if (mode[1])           state_nx = ST_EVENT;
                else if (uf)                state_nx = ST_PWM_NEXT_B;
            end
            ST_PWM_NEXT_B: begin
                if (mode == MODE_STOP)      state_nx = ST_STOPPED;
                else if (mode[1])           state_nx = ST_EVENT;
                else if (uf)                state_nx = ST_PWM_NEXT_A;
            end
            ST_EVENT: begin
                if (mode == MODE_STOP)      state_nx = ST_STOPPED;
                else if (mode == MODE_PWM)  state_nx = ST_PWM_NEXT_A;
            end
        endcase
    end

    // count strobes and reload selection
    always_comb begin
        dec        = 1'b0;
        reload_val = reload_a;
        unique case (state)
            ST_STOPPED:    dec = 1'b0;
            ST_PWM_NEXT_A: dec = tick;
            ST_PWM_NEXT_B: begin
                dec        = tick;
                reload_val = reload_b;
            end
            ST_EVENT:      dec = pin_edge;
        endcase
        uf       = dec && (count == '0);
        uf_a     = uf && (state != ST_PWM_NEXT_B);
        uf_b     = uf && (state == ST_PWM_NEXT_B);
        in_event = (state == ST_EVENT);
    end

    // counter datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (state == ST_STOPPED) begin
            if (wr_cnt_lo) count[7:0] <= wdata;
            if (wr_cnt_hi) count[W-1:8] <= wdata[HI_W-1:0];
        end else if (uf) begin
            count <= reload_val;
        end else if (dec) begin
            count <= count - 1'b1;
        end
    end

    // output process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwm <= 1'b0;
        end else if (state == ST_PWM_NEXT_A || state == ST_PWM_NEXT_B) begin
            if (uf) pwm <= ~pwm;
        end else begin
            pwm <= 1'b0;
        end
    end

    // R3: a stopped counter changes only through a byte write
    a_r3_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOPPED && !wr_cnt_lo && !wr_cnt_hi) |=> $stable(count));

    // R9: in event mode the counter moves only on a pin edge
    a_r9_event_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EVENT && !pin_edge) |=> $stable(count));

    // R4: two B reloads never follow each other
    a_r4_alternate: assert property (@(posedge clk) disable iff (!rst_n)
        uf_b |=> !uf_b);

    // R5: every waveform underflow flips the output
    a_r5_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        ((uf_a || uf_b) && state != ST_EVENT) |=> (pwm != $past(pwm)));
endmodule

// File: rtl/drt_flags.sv
module drt_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] pend
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n)      pend[i] <= 1'b0;
            else if (set[i]) pend[i] <= 1'b1;
            else if (clr[i]) pend[i] <= 1'b0;
        end

        // R7: a flag without a clear stays set
        a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (pend[i] && !clr[i]) |=> pend[i]);

        // R7: a set beats a same-cycle clear
        a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            set[i] |=> pend[i]);
    end
endmodule

// File: rtl/dual_reload_timer.sv
module dual_reload_timer
    import drt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              pin_a,
    input  logic              pin_b,
    output logic              pwm_out,
    output logic              irq
);
    localparam int NPIN = 2;

    logic [CNT_W-1:0] reload_a, reload_b, count;
    logic [1:0]       mode_bits;
    logic [NFLAG-1:0] en, pend, flag_set, flag_clr;
    logic [NPIN-1:0]  pin_raw, pin_fall_sel, pin_edge;
    logic             uf_a, uf_b, in_event;
    mode_e            mode;

    assign pin_raw      = {pin_b, pin_a};
    assign pin_fall_sel = {1'b0, mode_bits[0]};
    assign mode         = mode_e'(mode_bits);

    for (genvar p = 0; p < NPIN; p++) begin : g_pin
        drt_pin_sync #(.STAGES(2)) u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin      (pin_raw[p]),
            .fall_sel (pin_fall_sel[p]),
            .edge_det (pin_edge[p])
        );
    end

    // software-visible registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_a  <= '0;
            reload_b  <= '0;
            mode_bits <= '0;
            en        <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                ADR_RA_LO: reload_a[7:0]       <= bus_wdata;
                ADR_RA_HI: reload_a[CNT_W-1:8] <= bus_wdata;
                ADR_RB_LO: reload_b[7:0]       <= bus_wdata;
                ADR_RB_HI: reload_b[CNT_W-1:8] <= bus_wdata;
                ADR_CTRL: begin
                    mode_bits <= bus_wdata[1:0];
                    en        <= bus_wdata[3:2];
                end
                default: ;
            endcase
        end
    end

    drt_core #(.W(CNT_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .tick      (tick),
        .pin_edge  (pin_edge[0]),
        .wr_cnt_lo (bus_wr && bus_addr == ADR_CNT_LO),
        .wr_cnt_hi (bus_wr && bus_addr == ADR_CNT_HI),
        .wdata     (bus_wdata),
        .reload_a  (reload_a),
        .reload_b  (reload_b),
        .count     (count),
        .uf_a      (uf_a),
        .uf_b      (uf_b),
        .in_event  (in_event),
        .pwm       (pwm_out)
    );

    assign flag_set = {uf_b | (in_event & pin_edge[1]), uf_a};
    assign flag_clr = (bus_wr && bus_addr == ADR_FLAG) ? bus_wdata[NFLAG-1:0] : '0;

    drt_flags #(.N(NFLAG)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (flag_set),
        .clr   (flag_clr),
        .pend  (pend)
    );

    assign irq = |(pend & en);

    always_comb begin
        case (bus_addr)
            ADR_CNT_LO: bus_rdata = count[7:0];
            ADR_CNT_HI: bus_rdata = count[CNT_W-1:8];
            ADR_RA_LO:  bus_rdata = reload_a[7:0];
            ADR_RA_HI:  bus_rdata = reload_a[CNT_W-1:8];
            ADR_RB_LO:  bus_rdata = reload_b[7:0];
            ADR_RB_HI:  bus_rdata = reload_b[CNT_W-1:8];
            ADR_CTRL:   bus_rdata = {4'b0, en, mode_bits};
            ADR_FLAG:   bus_rdata = {{(BUS_W-NFLAG){1'b0}}, pend};
            default:    bus_rdata = '0;
        endcase
    end

    // R6: pending A rises only after an A reload
    a_r6_flag_a_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend[0]) |-> $past(uf_a));

    // R11: pending B rises only after a B reload or a pin-B edge in event mode
    a_r11_flag_b_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend[1]) |-> ($past(uf_b) || $past(in_event && pin_edge[1])));
endmodule

// File: tb/dual_reload_timer_tb_top.sv
module dual_reload_timer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int KIND_DATA = 0;
    localparam int KIND_IRQ  = 1;
    localparam int KIND_PWM  = 2;

    typedef struct {
        int         kind;
        int         req;
        logic [7:0] exp;
        logic [7:0] addr;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       pin_a = 1'b0;
    logic       pin_b = 1'b0;
    logic       pwm_out, irq;

    int    checks = 0;
    int    errors = 0;
    bit    mon_go = 1'b0;
    bit    done = 1'b0;
    item_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_reload_timer dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_a     (pin_a),
        .pin_b     (pin_b),
        .pwm_out   (pwm_out),
        .irq       (irq)
    );

    // monitor: pops expected items and compares mid-cycle
    always @(negedge clk) begin
        if (mon_go) begin
            while (exp_q.size() > 0) begin
                item_t it;
                logic [7:0] act;
                it = exp_q.pop_front();
                case (it.kind)
                    KIND_IRQ: act = {7'b0, irq};
                    KIND_PWM: act = {7'b0, pwm_out};
                    default:  act = bus_rdata;
                endcase
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL R%0d kind=%0d addr=%02h actual=%02h expected=%02h",
                             it.req, it.kind, it.addr, act, it.exp);
                end
            end
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        step();
        bus_wr = 1'b0;
    endtask

    task automatic pulse_tick();
        tick = 1'b1;
        step();
        tick = 1'b0;
    endtask

    task automatic tick_and_wr(input logic [7:0] a, input logic [7:0] d);
        tick = 1'b1; bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        step();
        tick = 1'b0; bus_wr = 1'b0;
    endtask

    // driver: pushes an expected item and lets the monitor sample it
    task automatic expect_item(input int kind, input logic [7:0] a,
                               input logic [7:0] e, input int req);
        item_t it;
        it.kind = kind; it.addr = a; it.exp = e; it.req = req;
        bus_addr = a;
        exp_q.push_back(it);
        mon_go = 1'b1;
        step();
        mon_go = 1'b0;
    endtask

    task automatic pin_a_pulse();
        pin_a = 1'b1; repeat (4) step();
        pin_a = 1'b0; repeat (4) step();
    endtask

    initial begin
        repeat (CLK_PERIOD * 20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R1: reset values
        for (int a = 0; a < 8; a++) expect_item(KIND_DATA, 8'(a), 8'h00, 1);
        expect_item(KIND_IRQ, 8'h00, 8'h00, 1);
        expect_item(KIND_PWM, 8'h00, 8'h00, 1);

        // R2: register readback and unmapped address
        wr(8'h02, 8'h3C); wr(8'h03, 8'hA5);
        expect_item(KIND_DATA, 8'h02, 8'h3C, 2);
        expect_item(KIND_DATA, 8'h03, 8'hA5, 2);
        wr(8'h02, 8'h02); wr(8'h03, 8'h00);
        wr(8'h04, 8'h01); wr(8'h05, 8'h00);
        expect_item(KIND_DATA, 8'h04, 8'h01, 2);
        expect_item(KIND_DATA, 8'h20, 8'h00, 2);

        // R3: counter write while stopped
        wr(8'h00, 8'h01); wr(8'h01, 8'h00);
        expect_item(KIND_DATA, 8'h00, 8'h01, 3);

        // R4: waveform mode, enable A
        wr(8'h06, 8'h05);
        step();
        expect_item(KIND_DATA, 8'h06, 8'h05, 2);
        pulse_tick();
        expect_item(KIND_DATA, 8'h00, 8'h00, 4);
        pulse_tick();                                   // first underflow -> A
        expect_item(KIND_DATA, 8'h00, 8'h02, 4);
        expect_item(KIND_DATA, 8'h07, 8'h01, 6);
        expect_item(KIND_PWM,  8'h00, 8'h01, 5);
        expect_item(KIND_IRQ,  8'h00, 8'h01, 8);

        // R3: writes ignored while running
        wr(8'h00, 8'h77); wr(8'h01, 8'h77);
        expect_item(KIND_DATA, 8'h00, 8'h02, 3);
        expect_item(KIND_DATA, 8'h01, 8'h00, 3);

        // R4/R6: second underflow reloads B
        pulse_tick(); pulse_tick(); pulse_tick();
        expect_item(KIND_DATA, 8'h00, 8'h01, 4);
        expect_item(KIND_DATA, 8'h07, 8'h03, 6);
        expect_item(KIND_PWM,  8'h00, 8'h00, 5);

        // R7/R8: clear A; B pending but disabled
        wr(8'h07, 8'h01);
        expect_item(KIND_DATA, 8'h07, 8'h02, 7);
        expect_item(KIND_IRQ,  8'h00, 8'h00, 8);
        wr(8'h06, 8'h09);
        expect_item(KIND_IRQ,  8'h00, 8'h01, 8);

        // R4: third underflow back to A
        pulse_tick(); pulse_tick();
        expect_item(KIND_DATA, 8'h00, 8'h02, 4);
        expect_item(KIND_PWM,  8'h00, 8'h01, 5);

        // R7: set wins over same-cycle clear (B reload with clear of both)
        pulse_tick(); pulse_tick();
        tick_and_wr(8'h07, 8'h03);
        expect_item(KIND_DATA, 8'h07, 8'h02, 7);
        expect_item(KIND_DATA, 8'h00, 8'h01, 4);

        // R11: pin B ignored in waveform mode
        pin_b = 1'b1; repeat (4) step();
        pin_b = 1'b0; repeat (4) step();
        expect_item(KIND_DATA, 8'h07, 8'h02, 11);

        // A reload, so the next reload would be B
        pulse_tick(); pulse_tick();
        expect_item(KIND_DATA, 8'h07, 8'h03, 6);

        // R12: stop holds the count, R5: output low when stopped
        wr(8'h06, 8'h00);
        step();
        pulse_tick(); pulse_tick();
        expect_item(KIND_DATA, 8'h00, 8'h02, 12);
        expect_item(KIND_PWM,  8'h00, 8'h00, 5);

        // R12: re-arm restarts with A
        wr(8'h00, 8'h00);
        wr(8'h07, 8'h03);
        wr(8'h06, 8'h01);
        step();
        pulse_tick();
        expect_item(KIND_DATA, 8'h00, 8'h02, 12);
        expect_item(KIND_DATA, 8'h07, 8'h01, 12);

        // R9: rising-edge event mode
        wr(8'h06, 8'h00);
        step();
        wr(8'h00, 8'h01);
        wr(8'h07, 8'h03);
        wr(8'h06, 8'h06);
        step();
        pulse_tick(); pulse_tick();
        expect_item(KIND_DATA, 8'h00, 8'h01, 9);
        pin_a_pulse();
        expect_item(KIND_DATA, 8'h00, 8'h00, 9);

        // R10: event underflow reloads A, sets only A
        pin_a_pulse();
        expect_item(KIND_DATA, 8'h00, 8'h02, 10);
        expect_item(KIND_DATA, 8'h07, 8'h01, 10);
        expect_item(KIND_IRQ,  8'h00, 8'h01, 10);
        expect_item(KIND_PWM,  8'h00, 8'h00, 5);

        // R11: pin B in event mode sets pending B
        pin_b = 1'b1; repeat (4) step();
        pin_b = 1'b0; repeat (4) step();
        expect_item(KIND_DATA, 8'h07, 8'h03, 11);
        wr(8'h07, 8'h01);
        expect_item(KIND_IRQ,  8'h00, 8'h00, 8);

        // R9: falling-edge event mode
        wr(8'h06, 8'h07);
        pin_a = 1'b1; repeat (4) step();
        expect_item(KIND_DATA, 8'h00, 8'h02, 9);
        pin_a = 1'b0; repeat (4) step();
        expect_item(KIND_DATA, 8'h00, 8'h01, 9);

        repeat (2) step();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule